// File: doc/BRIEF.md
# Folded Pipelined SHA-256 Compression Engine

This block computes the SHA-256 compression function for one 512-bit message block, starting from a 256-bit chaining state that the caller supplies. The 64 rounds are spread over a chain of round stages. Each stage loops its own result back to its own inputs, so that one stage covers `FOLD` adjacent rounds. With the default `FOLD = 2` there are 32 stages, and stage k performs rounds 2k and 2k+1. Feedback never leaves a stage. No path runs from the last stage back to the first.

Each stage carries a 16-word message-schedule window forward, together with the eight working variables and the chaining state of its block. The round constant is the only control that changes from cycle to cycle. A phase bit picks between the stage's two constants.

Seen from outside, the engine is a plain pipeline that runs at half the clock rate. A caller may present a new block on every other cycle, and results emerge in order, one per accepted block. Padding, multi-block messages and any outer hashing loop belong to the caller.

Top module: `sha_fold_core`

## Requirements
- R1: After synchronous reset, `out_valid` is low and `out_digest` is zero, and `out_valid` stays low until an accepted block completes.
- R2: For an accepted block, `out_digest` equals the SHA-256 compression of `in_block` starting from `in_chain`. The 64 working-variable rounds are followed by a word-wise modulo-2^32 addition of the chaining state. Word 0 sits in bits [255:224] for both chain and digest, and message word 0 sits in bits [511:480] of `in_block`. The padded message "abc" from the standard initial values yields ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R3: `out_valid` is high in the cycle that follows the 64th rising edge, counting the edge that samples `in_valid` high as the first.
- R4: With `FOLD = 2`, blocks may be presented on every other cycle, or with any larger gap. All blocks in flight complete in order, and each completes with the latency of R3.
- R5: `out_valid` is a one-cycle pulse per accepted block. With `FOLD = 2` it is never high on two consecutive cycles.
- R6: Values on `in_block` and `in_chain` while `in_valid` is low start no computation and produce no result.
- R7: `out_digest` keeps its value between results.
- R8: The chaining state travels with its own block. Blocks in flight with different chaining states each receive their own sum.
- R9: With `FOLD = 2`, the caller never drives `in_valid` high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block and chain present this cycle |
| in_chain | input | 256 | Chaining state, word 0 in the top bits |
| in_block | input | 512 | Message block, word 0 in the top bits |
| out_valid | output | 1 | Digest valid pulse |
| out_digest | output | 256 | Chaining state plus final working variables |

## Verification
An error in any one round, schedule word or constant selection spreads through every following round. It therefore shows as a wrong digest on that block's own result, 64 edges after it entered. A stage whose phase bit sticks or slips hands over early, late or twice. At the ports this shows as a result pulse off its expected cycle, as a missing or extra pulse, or as a digest that belongs to a neighbouring block when several blocks are in flight. A chaining state that does not travel with its block is exposed only when blocks in flight carry different chains, so the streaming tests vary the chain per block.

// File: rtl/shafold_pkg.sv
package shafold_pkg;
  typedef logic [31:0] word_t;
  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } wvars_t;
  typedef logic [15:0][31:0] win_t;   // index 0 = word used by the next round

  localparam int unsigned ROUNDS = 64;

  localparam word_t KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t round_const(input int unsigned idx);
    return KTAB[idx[5:0]];
  endfunction

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  // One compression round on the working variables.
  function automatic wvars_t do_round(input wvars_t v, input word_t k, input word_t w);
    word_t t1, t2;
    wvars_t r;
    t1 = v.h + big_sig1(v.e) + ((v.e & v.f) ^ (~v.e & v.g)) + k + w;
    t2 = big_sig0(v.a) + ((v.a & v.b) ^ (v.a & v.c) ^ (v.b & v.c));
    r.a = t1 + t2;
    r.b = v.a;
    r.c = v.b;
    r.d = v.c;
    r.e = v.d + t1;
    r.f = v.e;
    r.g = v.f;
    r.h = v.g;
    return r;
  endfunction

  // Advance the schedule window by one word.
  function automatic win_t shift_win(input win_t s);
    word_t nw;
    nw = sml_sig1(s[14]) + s[9] + sml_sig0(s[1]) + s[0];
    return {nw, s[15:1]};
  endfunction
endpackage

// File: rtl/sha_fold_stage.sv
module sha_fold_stage
  import shafold_pkg::*;
#(
  parameter int FOLD = 2,
  parameter int BASE = 0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   in_vld,
  input  wvars_t in_vars,
  input  win_t   in_win,
  input  wvars_t in_chain,
  output logic   out_vld,
  output wvars_t out_vars,
  output win_t   out_win,
  output wvars_t out_chain
);
  logic   phase;
  wvars_t src_vars;
  win_t   src_win;
  word_t  kc;

  always_comb begin
    src_vars = phase ? out_vars : in_vars;
    src_win  = phase ? out_win  : in_win;
    kc       = round_const(BASE + (phase ? 1 : 0));
  end

  generate
    if (FOLD == 1) begin : g_flat
      assign phase = 1'b0;
      always_ff @(posedge clk) begin
        if (in_vld) begin
          out_vars  <= do_round(src_vars, kc, src_win[0]);
          out_win   <= shift_win(src_win);
          out_chain <= in_chain;
        end
        if (rst) out_vld <= 1'b0;
        else     out_vld <= in_vld;
      end
    end else begin : g_fold
      logic phase_q;
      assign phase = phase_q;
      always_ff @(posedge clk) begin
        if (phase_q || in_vld) begin
          out_vars <= do_round(src_vars, kc, src_win[0]);
          out_win  <= shift_win(src_win);
        end
        if (!phase_q && in_vld) out_chain <= in_chain;
        if (rst) begin
          phase_q <= 1'b0;
          out_vld <= 1'b0;
        end else begin
          phase_q <= !phase_q && in_vld;
          out_vld <= phase_q;
        end
      end

      // R4: upstream hands over only while this stage is idle
      a_r4_arrive_idle: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> !phase_q);
      // R4: the second round follows at once and the block moves on
      a_r4_second_round: assert property (@(posedge clk) disable iff (rst)
        phase_q |=> (!phase_q && out_vld));
    end
  endgenerate
endmodule

// File: rtl/sha_fold_tail.sv
module sha_fold_tail
  import shafold_pkg::*;
#(
  parameter int FOLD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  wvars_t       in_vars,
  input  word_t        in_w0,
  input  word_t        in_w1,
  input  wvars_t       in_chain,
  output logic         out_valid,
  output logic [255:0] out_digest
);
  localparam int BASE = ROUNDS - FOLD;

  function automatic logic [255:0] add_chain(input wvars_t c, input wvars_t v);
    logic [7:0][31:0] cw, vw, sw;
    cw = c;
    vw = v;
    for (int i = 0; i < 8; i++) sw[i] = cw[i] + vw[i];
    return sw;
  endfunction

  generate
    if (FOLD == 1) begin : g_flat
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid  <= 1'b0;
          out_digest <= '0;
        end else begin
          out_valid <= in_vld;
          if (in_vld)
            out_digest <= add_chain(in_chain, do_round(in_vars, round_const(BASE), in_w0));
        end
      end
    end else begin : g_fold
      logic   phase_q;
      wvars_t vars_q, chain_q;
      word_t  w_q;
      always_ff @(posedge clk) begin
        if (!phase_q && in_vld) begin
          vars_q  <= do_round(in_vars, round_const(BASE), in_w0);
          w_q     <= in_w1;
          chain_q <= in_chain;
        end
        if (rst) begin
          phase_q    <= 1'b0;
          out_valid  <= 1'b0;
          out_digest <= '0;
        end else begin
          phase_q   <= !phase_q && in_vld;
          out_valid <= phase_q;
          if (phase_q)
            out_digest <= add_chain(chain_q, do_round(vars_q, round_const(BASE + 1), w_q));
        end
      end

      // R3: the final round completes on the edge after the capture
      a_r3_tail_finish: assert property (@(posedge clk) disable iff (rst)
        phase_q |=> out_valid);
      // R7: the digest changes only when a result is produced
      a_r7_digest_hold: assert property (@(posedge clk) disable iff (rst)
        !phase_q |=> $stable(out_digest));
    end
  endgenerate
endmodule

// File: rtl/sha_fold_core.sv
module sha_fold_core
  import shafold_pkg::*;
#(
  parameter int FOLD = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [255:0] in_chain,
  input  logic [511:0] in_block,
  output logic         out_valid,
  output logic [255:0] out_digest
);
  localparam int STAGES = ROUNDS / FOLD;
  localparam int NGEN   = STAGES - 1;

  logic   lvld   [NGEN+1];
  wvars_t lvars  [NGEN+1];
  win_t   lwin   [NGEN+1];
  wvars_t lchain [NGEN+1];

  always_comb begin
    lvld[0]   = in_valid;
    lvars[0]  = wvars_t'(in_chain);
    lchain[0] = wvars_t'(in_chain);
    for (int i = 0; i < 16; i++) lwin[0][i] = in_block[511 - 32*i -: 32];
  end

  generate
    for (genvar s = 0; s < NGEN; s++) begin : g_stage
      sha_fold_stage #(.FOLD(FOLD), .BASE(s * FOLD)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (lvld[s]),
        .in_vars  (lvars[s]),
        .in_win   (lwin[s]),
        .in_chain (lchain[s]),
        .out_vld  (lvld[s+1]),
        .out_vars (lvars[s+1]),
        .out_win  (lwin[s+1]),
        .out_chain(lchain[s+1])
      );
    end
  endgenerate

  sha_fold_tail #(.FOLD(FOLD)) u_tail (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (lvld[NGEN]),
    .in_vars   (lvars[NGEN]),
    .in_w0     (lwin[NGEN][0]),
    .in_w1     (lwin[NGEN][1]),
    .in_chain  (lchain[NGEN]),
    .out_valid (out_valid),
    .out_digest(out_digest)
  );

  generate
    if (FOLD == 2) begin : g_rate
      // R9: caller spaces blocks at least two cycles apart
      a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);
      // R5: one-cycle result pulses
      a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    end
  endgenerate
endmodule

// File: tb/sha_fold_core_tb.sv
module sha_fold_core_tb;
  import shafold_pkg::round_const;

  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [255:0] in_chain = '0;
  logic [511:0] in_block = '0;
  logic         out_valid;
  logic [255:0] out_digest;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int           exp_n, res_n;
  int           exp_cyc [MAXR];
  logic [255:0] exp_dig [MAXR];
  int           res_cyc [MAXR];
  logic [255:0] res_dig [MAXR];

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [255:0] ABC_DIG = {32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                                      32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};

  sha_fold_core #(.FOLD(2)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chain(in_chain),
    .in_block(in_block), .out_valid(out_valid), .out_digest(out_digest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (res_n < MAXR) begin
        res_cyc[res_n] = cyc;
        res_dig[res_n] = out_digest;
      end
      res_n = res_n + 1;
    end
  end

  // ---------------- independent reference ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input logic [255:0] ch, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int j = 0; j < 8; j++) v[j] = ch[255 - 32*j -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + round_const(t) + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int j = 0; j < 8; j++) r[255 - 32*j -: 32] = ch[255 - 32*j -: 32] + v[j];
    return r;
  endfunction

  function automatic logic [511:0] gen_block(input int seed);
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[511 - 32*i -: 32] = 32'h9e3779b9 * (seed + 1) + 32'h01000193 * i;
    return b;
  endfunction

  function automatic logic [255:0] gen_chain(input int seed);
    return IV ^ {8{32'h5bd1e995 * seed}};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    exp_n = 0;
    res_n = 0;
  endtask

  // called at a negedge; the block is sampled at the next posedge
  task automatic send(input logic [255:0] ch, input logic [511:0] blk, input int gap);
    in_valid = 1'b1;
    in_chain = ch;
    in_block = blk;
    exp_cyc[exp_n] = cyc + 64;
    exp_dig[exp_n] = ref_hash(ch, blk);
    exp_n++;
    @(negedge clk);
    in_valid = 1'b0;
    in_chain = ~ch;
    in_block = ~blk;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic check_log(input string req);
    repeat (72) @(negedge clk);
    chk(res_n == exp_n, "R5", {req, " result count"}, res_n, exp_n);
    for (int i = 0; i < exp_n && i < res_n; i++) begin
      chk(res_cyc[i] == exp_cyc[i], "R3", {req, " result cycle"}, res_cyc[i], exp_cyc[i]);
      chk(res_dig[i] == exp_dig[i], req, "digest", res_dig[i], exp_dig[i]);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_digest == '0, "R1", "digest after reset", out_digest, 0);
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid idle", out_valid, 0);
  endtask

  task automatic t_abc();
    logic [511:0] b;
    b = '0;
    b[511:480] = 32'h61626380;
    b[31:0]    = 32'h00000018;
    clear_log();
    send(IV, b, 2);
    check_log("R2");
    chk(res_dig[0] == ABC_DIG, "R2", "published abc digest", res_dig[0], ABC_DIG);
  endtask

  task automatic t_stream();
    clear_log();
    for (int i = 0; i < 8; i++) send(gen_chain(i + 3), gen_block(i), 2);
    check_log("R4");
    for (int i = 1; i < res_n && i < MAXR; i++)
      chk(res_cyc[i] - res_cyc[i-1] == 2, "R4", "stream spacing", res_cyc[i] - res_cyc[i-1], 2);
  endtask

  task automatic t_chain_mix();
    clear_log();
    send(IV, gen_block(20), 2);
    send(gen_chain(21), gen_block(20), 2);
    send(~IV, gen_block(20), 2);
    check_log("R8");
  endtask

  task automatic t_gaps();
    clear_log();
    send(gen_chain(30), gen_block(31), 3);
    send(gen_chain(32), gen_block(33), 5);
    send(gen_chain(34), gen_block(35), 2);
    send(gen_chain(36), gen_block(37), 7);
    check_log("R4");
  endtask

  task automatic t_idle_hold();
    logic [255:0] held;
    held = out_digest;
    clear_log();
    for (int i = 0; i < 80; i++) begin
      in_chain = gen_chain(100 + i);
      in_block = gen_block(200 + i);
      @(negedge clk);
    end
    chk(res_n == 0, "R6", "results from idle inputs", res_n, 0);
    chk(out_digest == held, "R7", "digest held while idle", out_digest, held);
  endtask

  initial begin
    t_reset();
    t_abc();
    t_stream();
    t_chain_mix();
    t_gaps();
    t_idle_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule